// File: doc/BRIEF.md
# 3-Wire Serial EEPROM Slave

This block models the device side of a small serial EEPROM of 256 words by 16 bits. A host selects it with a chip-select line, clocks command bits in on a serial data input at each rising edge of a serial clock, and reads results back on a serial data output. The block discards any number of leading clocks taken with the data input low. The first clock taken with the data input high is the start bit. After it come a 2-bit opcode and an 8-bit word address, then 16 data bits if the command is a write.

The serial lines are sampled by a system clock, and their edges are detected inside the block. A write or erase takes effect when chip-select falls after a complete command. An internal programming time then follows, counted in system clocks. If chip-select is raised during that time or after it, the data output reports status instead of starting a new command. It shows 0 while the cycle is in progress and 1 once it is done. The output is modelled as a value plus an output enable.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the output enable is low and writes are disabled, so a WRITE sent before any enable command leaves the addressed word unchanged.
- R2: With chip-select high, clocks taken while the data input is low before the start bit are ignored, and any count of them (including zero) gives the same result.
- R3: While chip-select is low the output enable is low and serial clock and data activity has no effect on memory contents.
- R4: READ (opcode bits 1,0 sent in that order) drives a 0 on the output right after the last address bit. The 16 data bits of the addressed word follow, MSB first, each updated on a rising serial clock edge. The output enable drops on the rising edge after the LSB.
- R5: WRITE (opcode bits 0,1) takes 16 data bits MSB first and stores them at the address when chip-select falls, provided writes are enabled.
- R6: ERASE (opcode bits 1,1) sets the addressed word to 0xFFFF when chip-select falls, provided writes are enabled.
- R7: Opcode 00 with address bits [7:6] = 11 enables writes, and opcode 00 with address bits [7:6] = 00 disables them. A WRITE or ERASE while writes are disabled changes nothing.
- R8: A WRITE whose chip-select falls before all 16 data bits are received changes nothing and starts no programming time.
- R9: For WR_CLKS system clocks after a committed write or erase, raising chip-select enables the output and shows 0. The output then shows 1 once the time has elapsed.
- R10: During the status period a high data input on a rising serial clock edge is not taken as a start bit. A new command is accepted only after chip-select has gone low and high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from host |
| di | input | 1 | Serial data from host |
| do_o | output | 1 | Serial data / status to host |
| do_oe | output | 1 | Output enable for do_o |

## Verification
The assertions check the following on every cycle:
- The output is disabled in standby.
- A command only begins on a high data bit at a serial clock edge.
- Read data moves only on a serial clock edge.
- Memory is committed only on a chip-select fall with writes enabled.
- The status value follows an independent copy of the programming timer.
- The status period is left only through standby.

The bench scenarios show the rest:
- Stored words, erase values and the handling of enable and disable.
- Behaviour across reset.
- That truncated commands, commands in standby and bits clocked during the status period all leave memory unchanged.

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int WR_CLKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int OPW = 2;
  localparam int CW  = OPW + AW;
  localparam int NW  = 1 << AW;
  localparam int BCW = $clog2(((CW > DW) ? CW : DW) + 1);
  localparam int TW  = $clog2(WR_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_CMD, S_WDAT, S_RD, S_HOLD, S_STAT} st_t;

  st_t            st;
  logic           cs_d, sk_d, do_r, wen, pend;
  logic [CW-1:0]  cmd_sr;
  logic [BCW-1:0] bcnt;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdat, rd_sr;
  logic [TW-1:0]  cnt;
  logic [DW-1:0]  mem [NW];

  wire sk_rise = cs & sk & ~sk_d;
  wire cs_rise = cs & ~cs_d;
  wire cs_fall = ~cs & cs_d;
  wire we      = cs_fall & pend & wen;
  wire busy    = (cnt != '0);

  wire [CW-1:0]  cmd_nx = {cmd_sr[CW-2:0], di};
  wire [OPW-1:0] opc    = cmd_nx[CW-1 -: OPW];
  wire [AW-1:0]  adr    = cmd_nx[AW-1:0];

  assign do_oe = cs & ((st == S_RD) | (st == S_STAT));
  assign do_o  = (st == S_STAT) ? ~busy : do_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_d <= 1'b0;
      sk_d <= 1'b0;
    end else begin
      cs_d <= cs;
      sk_d <= sk;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (we)   cnt <= TW'(WR_CLKS);
    else if (busy) cnt <= cnt - 1'b1;

  always_ff @(posedge clk)
    if (we) mem[addr_q] <= wdat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cmd_sr <= '0;
      bcnt   <= '0;
      addr_q <= '0;
      wdat   <= '0;
      rd_sr  <= '0;
      do_r   <= 1'b0;
      wen    <= 1'b0;
      pend   <= 1'b0;
    end else if (cs_fall) begin
      st   <= S_IDLE;
      pend <= 1'b0;
    end else if (cs_rise) begin
      st   <= busy ? S_STAT : S_WAIT;
      bcnt <= '0;
      pend <= 1'b0;
    end else if (sk_rise) begin
      case (st)
        S_WAIT:
          if (di) begin
            st     <= S_CMD;
            bcnt   <= '0;
            cmd_sr <= '0;
          end
        S_CMD: begin
          cmd_sr <= cmd_nx;
          if (bcnt == BCW'(CW - 1)) begin
            addr_q <= adr;
            bcnt   <= '0;
            case (opc)
              2'b10: begin
                rd_sr <= mem[adr];
                do_r  <= 1'b0;
                st    <= S_RD;
              end
              2'b01: st <= S_WDAT;
              2'b11: begin
                wdat <= '1;
                pend <= 1'b1;
                st   <= S_HOLD;
              end
              default: begin
                if (adr[AW-1 -: 2] == 2'b11) wen <= 1'b1;
                if (adr[AW-1 -: 2] == 2'b00) wen <= 1'b0;
                st <= S_HOLD;
              end
            endcase
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        S_WDAT: begin
          wdat <= {wdat[DW-2:0], di};
          if (bcnt == BCW'(DW - 1)) begin
            pend <= 1'b1;
            st   <= S_HOLD;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        S_RD:
          if (bcnt == BCW'(DW)) begin
            st <= S_HOLD;
          end else begin
            do_r  <= rd_sr[DW-1];
            rd_sr <= {rd_sr[DW-2:0], 1'b0};
            bcnt  <= bcnt + 1'b1;
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/serial_eeprom_slave_chk.sv
module serial_eeprom_slave_chk #(
  parameter int WR_CLKS = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       di,
  input logic       sk_rise,
  input logic       we,
  input logic       wen,
  input logic [2:0] st,
  input logic       do_o,
  input logic       do_oe
);
  localparam logic [2:0] C_WAIT = 3'd1, C_CMD = 3'd2, C_RD = 3'd4, C_STAT = 3'd6, C_IDLE = 3'd0;

  int unsigned ccnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         ccnt <= 0;
    else if (we)        ccnt <= WR_CLKS;
    else if (ccnt != 0) ccnt <= ccnt - 1;

  p_standby_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !do_oe);

  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_CMD && $past(st) == C_WAIT) |-> $past(di && sk_rise));

  p_rd_edge_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RD && $past(st) == C_RD && !$past(sk_rise)) |-> $stable(do_o));

  p_commit_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> wen);

  p_commit_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (!cs && $past(cs)));

  p_busy_shows_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_oe && st == C_STAT && ccnt != 0) |-> !do_o);

  p_ready_shows_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_oe && st == C_STAT && ccnt == 0) |-> do_o);

  p_status_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_STAT) |=> (st == C_STAT || st == C_IDLE));
endmodule

bind serial_eeprom_slave serial_eeprom_slave_chk #(.WR_CLKS(WR_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .sk_rise(sk_rise), .we(we),
  .wen(wen), .st(st), .do_o(do_o), .do_oe(do_oe)
);

// File: tb/sim_serial_eeprom_slave.sv
module sim_serial_eeprom_slave;
  localparam int WR = 40;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serial_eeprom_slave #(.AW(8), .DW(16), .WR_CLKS(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe));

  localparam logic [23:0] VEC [6] = '{
    {8'h00, 16'hA5C3}, {8'hFF, 16'h8001}, {8'h3C, 16'h0000},
    {8'h81, 16'hFFFE}, {8'h42, 16'h1234}, {8'h7E, 16'h5A5A}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bitclk(input logic b);
    @(negedge clk) di = b;
    @(negedge clk) sk = 1'b1;
    @(negedge clk);
    @(negedge clk) sk = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_up();
    @(negedge clk) cs = 1'b1;
    @(negedge clk);
  endtask

  task automatic cs_dn();
    @(negedge clk) begin cs = 1'b0; di = 1'b0; end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic hdr(input int nd, input logic [1:0] op, input logic [7:0] a);
    cs_up();
    repeat (nd) bitclk(1'b0);
    bitclk(1'b1);
    for (int i = 1; i >= 0; i--) bitclk(op[i]);
    for (int i = 7; i >= 0; i--) bitclk(a[i]);
  endtask

  task automatic settle();
    repeat (WR + 8) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input int nd);
    hdr(nd, 2'b01, a);
    for (int i = 15; i >= 0; i--) bitclk(d[i]);
    cs_dn();
    settle();
  endtask

  task automatic ctl(input logic [7:0] a);
    hdr(5, 2'b00, a);
    cs_dn();
  endtask

  task automatic rd(input logic [7:0] a, input int nd, output logic [15:0] d,
                    output bit dummy_ok, output bit oe_drop);
    hdr(nd, 2'b10, a);
    dummy_ok = do_oe && !do_o;
    for (int i = 15; i >= 0; i--) begin
      bitclk(1'b0);
      d[i] = do_oe ? do_o : 1'bx;
    end
    bitclk(1'b0);
    oe_drop = !do_oe;
    cs_dn();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    bit dok, odr;
    repeat (4) @(negedge clk);
    chk(do_oe == 1'b0, "R1 reset output enable", do_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(do_oe == 1'b0, "R1 idle after reset", do_oe, 0);

    ctl(8'hC0);
    foreach (VEC[k]) wr(VEC[k][23:16], VEC[k][15:0], 5);
    foreach (VEC[k]) begin
      rd(VEC[k][23:16], 5, d, dok, odr);
      chk(d == VEC[k][15:0], "R5 stored word", d, VEC[k][15:0]);
      chk(dok, "R4 dummy zero", dok, 1);
      chk(odr, "R4 enable drops after LSB", odr, 1);
    end

    wr(8'h10, 16'h1357, 0);
    rd(8'h10, 9, d, dok, odr);
    chk(d == 16'h1357, "R2 zero and nine dummy clocks", d, 16'h1357);

    wr(8'h05, 16'h1234, 5);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    wr(8'h05, 16'h5555, 5);
    rd(8'h05, 5, d, dok, odr);
    chk(d == 16'h1234, "R1 writes disabled after reset", d, 16'h1234);

    ctl(8'hC0);
    ctl(8'h00);
    wr(8'h05, 16'hBEEF, 5);
    hdr(5, 2'b11, 8'h05);
    cs_dn();
    settle();
    rd(8'h05, 5, d, dok, odr);
    chk(d == 16'h1234, "R7 disabled write and erase", d, 16'h1234);

    ctl(8'hC0);
    hdr(5, 2'b11, 8'h07);
    cs_dn();
    settle();
    rd(8'h07, 5, d, dok, odr);
    chk(d == 16'hFFFF, "R6 erase", d, 16'hFFFF);

    begin
      bit oe_seen = 1'b0;
      logic [15:0] pat = 16'h0F0F;
      logic [10:0] h = {1'b1, 2'b01, 8'h05};
      for (int i = 10; i >= 0; i--) begin bitclk(h[i]); oe_seen |= do_oe; end
      for (int i = 15; i >= 0; i--) begin bitclk(pat[i]); oe_seen |= do_oe; end
      chk(!oe_seen, "R3 standby output off", oe_seen, 0);
    end
    settle();
    rd(8'h05, 5, d, dok, odr);
    chk(d == 16'h1234, "R3 standby no write", d, 16'h1234);

    hdr(5, 2'b01, 8'h05);
    for (int i = 15; i >= 8; i--) bitclk(1'b1);
    cs_dn();
    cs_up();
    chk(do_oe == 1'b0, "R8 no status after truncated write", do_oe, 0);
    cs_dn();
    rd(8'h05, 5, d, dok, odr);
    chk(d == 16'h1234, "R8 truncated write", d, 16'h1234);

    hdr(5, 2'b01, 8'h0A);
    for (int i = 15; i >= 0; i--) bitclk(1'b0);
    cs_dn();
    cs_up();
    chk(do_oe && do_o == 1'b0, "R9 busy status", {do_oe, do_o}, 2'b10);
    settle();
    chk(do_oe && do_o == 1'b1, "R9 ready status", {do_oe, do_o}, 2'b11);
    begin
      logic [10:0] h = {1'b1, 2'b01, 8'h05};
      bit bad = 1'b0;
      for (int i = 10; i >= 0; i--) begin bitclk(h[i]); bad |= !(do_oe && do_o); end
      for (int i = 15; i >= 0; i--) begin bitclk(1'b1); bad |= !(do_oe && do_o); end
      chk(!bad, "R10 status held while clocking", bad, 0);
    end
    cs_dn();
    settle();
    rd(8'h05, 5, d, dok, odr);
    chk(d == 16'h1234, "R10 no start in status period", d, 16'h1234);
    rd(8'h0A, 5, d, dok, odr);
    chk(d == 16'h0000, "R9 committed word", d, 16'h0000);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule